// File: doc/BRIEF.md
# Prioritized Interrupt Vector Fetch Unit

This block resolves the target of a vectored jump in a small 8-bit controller. When the core executes its vector-jump instruction, it presents the instruction's byte address, a 16-bit word of pending interrupt flags and a matching word of enable flags, and pulses a request. The unit selects the highest-ranked source that may be serviced. It locates that source's two-byte entry in a vector table stored in byte memory and reads the entry through a synchronous read port with one cycle of latency. It then returns a 15-bit jump target together with a single-cycle done strobe.

The table sits in the top 32 bytes of a 256-byte page, with one byte pair per rank. The pair for rank 0 is at the lowest offset, and the software trap (rank 15) is at the highest. The page is normally the one that holds the instruction. If the instruction occupies the last byte of its page, the next page up is used. When no source qualifies, the unit fetches the rank-0 pair as a default error vector and flags the result as having no source.

Top module: `irq_vector_fetch`

## Requirements
- R1: After reset, `busy`, `memRdEn`, `doneStrobe` and `noSource` are all 0.
- R2: The table page is the instruction address bits [14:8]. If instruction bits [7:0] equal 8'hFF, the page is those bits plus one, wrapping modulo 128.
- R3: The high-byte read is issued in the cycle after the request is accepted, at byte address {page, 3'b111, rank, 1'b0}. The low-byte read follows in the next cycle at that address plus one. Each read asserts `memRdEn` for exactly one cycle.
- R4: `doneStrobe` is high in the cycle after the low-byte read. In that cycle `jumpTarget` equals {highByte[6:0], lowByte}, and bit 7 of the high byte is dropped.
- R5: Only sources whose pending and enable bits are both 1 take part. Among those sources, the one with the largest index (rank) wins.
- R6: Source 15, the software trap, takes part whenever its pending bit is 1, whatever the value of its enable bit.
- R7: When no source takes part, the rank-0 pair (offsets E0/E1) is fetched and `noSource` is 1 in the done cycle. `noSource` is 0 in every other cycle.
- R8: A request made while `busy` is 1 (including the done cycle) is ignored. It does not change the addresses being read or the result, and it starts no new read.
- R9: `doneStrobe` lasts one cycle. `busy` is 1 from the cycle after acceptance through the done cycle, and returns to 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Start a vector fetch (accepted only when not busy) |
| instrAddr | input | 15 | Byte address of the vector-jump instruction |
| pendFlags | input | 16 | Pending interrupt flags, bit 15 = software trap |
| enFlags | input | 16 | Interrupt enable flags |
| busy | output | 1 | Fetch in progress |
| memRdEn | output | 1 | Memory read request |
| memAddr | output | 15 | Memory byte address |
| memRdData | input | 8 | Read data, valid one cycle after `memRdEn` |
| doneStrobe | output | 1 | One-cycle result-valid strobe |
| jumpTarget | output | 15 | Resolved jump target, valid with `doneStrobe` |
| noSource | output | 1 | No source qualified; default vector used |

## Verification
The hardest situation to reach from the ports is a second request that arrives while a fetch is in flight, and in particular one that arrives in the done cycle. In that cycle the unit is about to go idle, so a premature return to idle would make it accept the request. The bench holds `reqValid` high with different flags through every busy cycle, including the done cycle. It then checks that the read addresses and the result belong to the first request and that no read follows. Page wrap at the top of the address space, where instruction address 0x7FFF must select page 0, is driven directly.

// File: rtl/ivf_pkg.sv
package ivf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_READ_HI = 2'd1,
    ST_READ_LO = 2'd2,
    ST_DONE    = 2'd3
  } fetchState_e;

  typedef struct packed {
    logic loadReq;
    logic issueHi;
    logic issueLo;
    logic captureHi;
    logic finish;
  } ctrlStrobe_t;

endpackage

// File: rtl/ivf_prio_enc.sv
module ivf_prio_enc #(
  parameter int SRC_N = 16,
  localparam int RANK_W = $clog2(SRC_N)
) (
  input  logic [SRC_N-1:0]  pendFlags,
  input  logic [SRC_N-1:0]  enFlags,
  output logic [RANK_W-1:0] winRank,
  output logic              anyValid
);

  logic [SRC_N-1:0] qualify;

  for (genvar g = 0; g < SRC_N; g++) begin : g_qual
    if (g == SRC_N - 1) begin : g_trap
      assign qualify[g] = pendFlags[g];
    end else begin : g_mask
      assign qualify[g] = pendFlags[g] & enFlags[g];
    end
  end

  always_comb begin
    winRank  = '0;
    anyValid = 1'b0;
    for (int i = 0; i < SRC_N; i++) begin
      if (qualify[i]) begin
        winRank  = RANK_W'(i);
        anyValid = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ivf_ctrl.sv
module ivf_ctrl
  import ivf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        busy,
  output ctrlStrobe_t strobe
);

  fetchState_e state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:    if (reqValid) stateNext = ST_READ_HI;
      ST_READ_HI: stateNext = ST_READ_LO;
      ST_READ_LO: stateNext = ST_DONE;
      ST_DONE:    stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.loadReq   = (state == ST_IDLE) && reqValid;
    strobe.issueHi   = (state == ST_READ_HI);
    strobe.issueLo   = (state == ST_READ_LO);
    strobe.captureHi = (state == ST_READ_LO);
    strobe.finish    = (state == ST_DONE);
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/ivf_datapath.sv
module ivf_datapath
  import ivf_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int SRC_N  = 16,
  parameter int DATA_W = 8,
  localparam int PAGE_W = ADDR_W - 8,
  localparam int RANK_W = $clog2(SRC_N),
  localparam int ONES_W = 8 - RANK_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] instrAddr,
  input  logic [SRC_N-1:0]  pendFlags,
  input  logic [SRC_N-1:0]  enFlags,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] jumpTarget,
  output logic              doneStrobe,
  output logic              noSource
);

  logic [RANK_W-1:0] winRank;
  logic              anyValid;
  logic [PAGE_W-1:0] pageCalc;
  logic [PAGE_W-1:0] pageReg;
  logic [RANK_W-1:0] rankReg;
  logic              noneReg;
  logic [DATA_W-2:0] hiReg;

  ivf_prio_enc #(.SRC_N(SRC_N)) u_prio (
    .pendFlags (pendFlags),
    .enFlags   (enFlags),
    .winRank   (winRank),
    .anyValid  (anyValid)
  );

  always_comb begin
    pageCalc = instrAddr[ADDR_W-1:8];
    if (instrAddr[7:0] == 8'hFF) pageCalc = pageCalc + PAGE_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg <= '0;
      rankReg <= '0;
      noneReg <= 1'b0;
    end else if (strobe.loadReq) begin
      pageReg <= pageCalc;
      rankReg <= winRank;
      noneReg <= ~anyValid;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 hiReg <= '0;
    else if (strobe.captureHi) hiReg <= memRdData[DATA_W-2:0];
  end

  assign memRdEn    = strobe.issueHi | strobe.issueLo;
  assign memAddr    = {pageReg, {ONES_W{1'b1}}, rankReg, strobe.issueLo};
  assign jumpTarget = {hiReg, memRdData};
  assign doneStrobe = strobe.finish;
  assign noSource   = strobe.finish & noneReg;

endmodule

// File: rtl/irq_vector_fetch.sv
module irq_vector_fetch
  import ivf_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int SRC_N  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] instrAddr,
  input  logic [SRC_N-1:0]  pendFlags,
  input  logic [SRC_N-1:0]  enFlags,
  output logic              busy,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              doneStrobe,
  output logic [ADDR_W-1:0] jumpTarget,
  output logic              noSource
);

  ctrlStrobe_t strobe;

  ivf_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .busy     (busy),
    .strobe   (strobe)
  );

  ivf_datapath #(.ADDR_W(ADDR_W), .SRC_N(SRC_N), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .instrAddr  (instrAddr),
    .pendFlags  (pendFlags),
    .enFlags    (enFlags),
    .memRdData  (memRdData),
    .memRdEn    (memRdEn),
    .memAddr    (memAddr),
    .jumpTarget (jumpTarget),
    .doneStrobe (doneStrobe),
    .noSource   (noSource)
  );

endmodule

// File: rtl/ivf_checker.sv
module ivf_checker #(
  parameter int ADDR_W = 15,
  parameter int SRC_N  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] instrAddr,
  input logic [SRC_N-1:0]  pendFlags,
  input logic [SRC_N-1:0]  enFlags,
  input logic              busy,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              doneStrobe,
  input logic              noSource
);

  logic accept;
  assign accept = reqValid && !busy;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memRdEn && !doneStrobe));

  assert_same_page_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accept && instrAddr[7:0] != 8'hFF) |=> (memRdEn && memAddr[ADDR_W-1:8] == $past(instrAddr[ADDR_W-1:8])));

  assert_table_region_R3: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> memAddr[7:5] == 3'b111);

  assert_lo_follows_hi_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && !memAddr[0]) |=> (memRdEn && memAddr == $past(memAddr) + ADDR_W'(1)));

  assert_done_after_lo_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && memAddr[0]) |=> (doneStrobe && !memRdEn));

  assert_empty_slot_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accept && (pendFlags & enFlags) == '0 && !pendFlags[SRC_N-1]) |=> memAddr[4:0] == 5'h00);

  assert_trap_slot_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accept && pendFlags[SRC_N-1]) |=> (memRdEn && memAddr[4:0] == 5'h1E));

  assert_nosrc_in_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    noSource |-> doneStrobe);

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |=> !memRdEn);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |=> (!doneStrobe && !busy));

endmodule

bind irq_vector_fetch ivf_checker #(.ADDR_W(ADDR_W), .SRC_N(SRC_N)) u_ivf_checker (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .instrAddr  (instrAddr),
  .pendFlags  (pendFlags),
  .enFlags    (enFlags),
  .busy       (busy),
  .memRdEn    (memRdEn),
  .memAddr    (memAddr),
  .doneStrobe (doneStrobe),
  .noSource   (noSource)
);

// File: tb/test_irq_vector_fetch.sv
module test_irq_vector_fetch;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [14:0] instrAddr = '0;
  logic [15:0] pendFlags = '0;
  logic [15:0] enFlags = '0;
  logic        busy;
  logic        memRdEn;
  logic [14:0] memAddr;
  logic [7:0]  memRdData;
  logic        doneStrobe;
  logic [14:0] jumpTarget;
  logic        noSource;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  irq_vector_fetch i_irq_vector_fetch (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .instrAddr  (instrAddr),
    .pendFlags  (pendFlags),
    .enFlags    (enFlags),
    .busy       (busy),
    .memRdEn    (memRdEn),
    .memAddr    (memAddr),
    .memRdData  (memRdData),
    .doneStrobe (doneStrobe),
    .jumpTarget (jumpTarget),
    .noSource   (noSource)
  );

  function automatic logic [7:0] memByte(input logic [14:0] a);
    logic [7:0] m;
    m = 8'(a[14:8] * 8'd37);
    return m ^ a[7:0] ^ 8'hA5;
  endfunction

  always_ff @(posedge clk) begin
    if (memRdEn) memRdData <= memByte(memAddr);
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] modelRank(input logic [15:0] p, input logic [15:0] e);
    logic [15:0] q;
    q = (p & e) | {p[15], 15'b0};
    for (int i = 15; i >= 0; i--) if (q[i]) return {1'b0, 4'(i)};
    return 5'b1_0000;
  endfunction

  function automatic logic [6:0] modelPage(input logic [14:0] ia);
    return (ia[7:0] == 8'hFF) ? 7'(ia[14:8] + 7'd1) : ia[14:8];
  endfunction

  // Full fetch: checks R2..R4, R7, R9 from the requirements' formulas.
  // busyP/busyE: flags presented during busy cycles (used for R8).
  task automatic runFetch(input logic [14:0] ia, input logic [15:0] p, input logic [15:0] e,
                          input bit holdBusy, input logic [15:0] busyP, input string tag);
    logic [4:0]  rk;
    logic [14:0] hiA;
    logic [14:0] expT;
    rk   = modelRank(p, e);
    hiA  = {modelPage(ia), 3'b111, rk[3:0], 1'b0};
    expT = {memByte(hiA)[6:0], memByte(hiA + 15'd1)};
    @(negedge clk);
    reqValid = 1'b1; instrAddr = ia; pendFlags = p; enFlags = e;
    @(negedge clk);
    if (holdBusy) begin
      instrAddr = ~ia; pendFlags = busyP; enFlags = 16'hFFFF;
    end else reqValid = 1'b0;
    check(busy, {tag, " R9 busy after accept"}, 32'(busy), 1);
    check(memRdEn && memAddr == hiA, {tag, " R3 high address"}, 32'(memAddr), 32'(hiA));
    check(memAddr[14:8] == modelPage(ia), {tag, " R2 page"}, 32'(memAddr[14:8]), 32'(modelPage(ia)));
    @(negedge clk);
    check(memRdEn && memAddr == hiA + 15'd1, {tag, " R3 low address"}, 32'(memAddr), 32'(hiA + 15'd1));
    @(negedge clk);
    check(doneStrobe && !memRdEn, {tag, " R4 done strobe"}, 32'(doneStrobe), 1);
    check(jumpTarget == expT, {tag, " R4 target"}, 32'(jumpTarget), 32'(expT));
    check(noSource == rk[4], {tag, " R7 no-source flag"}, 32'(noSource), 32'(rk[4]));
    @(negedge clk);
    reqValid = 1'b0;
    check(!doneStrobe && !noSource && !busy, {tag, " R9 single strobe"}, 32'({doneStrobe, noSource, busy}), 0);
    if (holdBusy) check(!memRdEn, {tag, " R8 no read after busy request"}, 32'(memRdEn), 0);
  endtask

  task automatic testReset();
    check(!busy && !memRdEn && !doneStrobe && !noSource, "R1 reset outputs",
          32'({busy, memRdEn, doneStrobe, noSource}), 0);
  endtask

  task automatic testPriority();
    runFetch(15'h0123, 16'h0008, 16'h0008, 0, 0, "R5 single source");
    runFetch(15'h0240, 16'h0A12, 16'hFFFF, 0, 0, "R5 highest wins");
    runFetch(15'h0310, 16'h0C01, 16'h0401, 0, 0, "R5 disabled ignored");
    runFetch(15'h0405, 16'h7FFF, 16'h4000, 0, 0, "R5 rank 14");
  endtask

  task automatic testTrap();
    runFetch(15'h0520, 16'h8001, 16'h0001, 0, 0, "R6 trap without enable");
    runFetch(15'h0633, 16'hFFFF, 16'hFFFF, 0, 0, "R6 trap over all");
  endtask

  task automatic testNoSource();
    runFetch(15'h0710, 16'h0000, 16'hFFFF, 0, 0, "R7 none pending");
    runFetch(15'h0811, 16'h7F00, 16'h00FF, 0, 0, "R7 none enabled");
  endtask

  task automatic testPageWrap();
    runFetch(15'h00FF, 16'h0002, 16'h0002, 0, 0, "R2 page step");
    runFetch(15'h7FFF, 16'h0020, 16'h0020, 0, 0, "R2 page wrap");
    runFetch(15'h01FE, 16'h0020, 16'h0020, 0, 0, "R2 byte FE same page");
  endtask

  task automatic testBusyIgnore();
    runFetch(15'h0900, 16'h0004, 16'h0004, 1, 16'h8000, "R8 request while busy");
    runFetch(15'h0A00, 16'h0000, 16'h0000, 1, 16'h0200, "R8 busy after none");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPriority();
    testTrap();
    testNoSource();
    testPageWrap();
    testBusyIgnore();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL R9 watchdog expired actual=%0d expected=0", 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule